// File: doc/BRIEF.md
# Machine-Cycle Bus Sequencer for an 8-bit Processor

This block turns machine-cycle requests from a processor core into the external bus timing of a classic 8-bit microprocessor. The core asks for one machine cycle at a time: an opcode fetch, a memory read, a memory write, an I/O read or an I/O write. It supplies the address, the write data and a flag that marks the last machine cycle of the current instruction. The sequencer steps through the clock states of that cycle. It drives the address lines, the memory and I/O request strobes, the read and write strobes, the fetch indicator and the refresh strobe. It stretches the cycle with wait states while a slow device holds its wait line low.

Every fetch cycle ends with two refresh states. During these states the upper address byte carries the interrupt-vector register and the lower byte carries the refresh register. The low seven bits of the refresh register count fetches, and its top bit is kept. The sequencer also owns bus arbitration. A bus request is honoured at the end of any machine cycle, even in the middle of an instruction. A maskable interrupt request is sampled only at the end of a cycle that the core marked as the last one of its instruction. When a cycle finishes, the core receives a one-clock done pulse, the captured read data and, when it applies, a one-clock interrupt-pending flag.

One clock period is one T-state. Cycle type codes on `cyc_type` are: 0 fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. All strobes are active low.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is asserted and after it is released, before any request: all six strobes are high, `busack_n` is high, `bus_en_n` is low, `cyc_done` and `irq_pend` are low, and the refresh register is 0x00.
- R2: A fetch lasts four states, T1 to T4. `m1_n` and `rd_n` are low in T1 and T2 (and in any wait state). `mreq_n` is low in all four states. `cyc_rdata` holds the `din` value sampled at the clock edge that ends the last state before T3.
- R3: In T3 and T4 of a fetch, `rfsh_n` is low, `m1_n` and `rd_n` are high, and `addr` equals {`ivec`, refresh register}. In the other states `addr` carries the requested address.
- R4: After each fetch, the low seven bits of the refresh register increase by one and wrap from 0x7F to 0x00, while bit 7 keeps its value. A pulse on `rr_load` loads `rr_din` into the whole register.
- R5: Memory read and memory write cycles last three states. `mreq_n` is low in all three. For a read, `rd_n` is low in all three. For a write, `wr_n` is low in T2 and T3, and `dout` carries the write data.
- R6: I/O cycles last four states: T1, T2, one automatic wait state, T3. `iorq_n` is low from T2 through T3, together with `rd_n` or `wr_n`. `mreq_n` stays high, and `wait_n` is not sampled in T2.
- R7: `wait_n` is sampled at the clock edge that ends T2 (for memory and fetch) or that ends the automatic wait state (for I/O), and again at the end of each inserted wait state. Every sample that finds it low adds one wait state, with the strobes held as in T2.
- R8: `busreq_n` is sampled only at the clock edge that ends a machine cycle (or while idle), so a request never shortens a cycle. Once granted, `busack_n` is low, `bus_en_n` is high and all strobes are high until `busreq_n` returns high. The block is idle one state later.
- R9: `int_n` is sampled only at the clock edge that ends a cycle requested with `cyc_last` high. If it is low there, `irq_pend` is high in the same clock as `cyc_done`.
- R10: `cyc_done` and `irq_pend` are one-clock pulses in the state right after the cycle's last state. For reads, `cyc_rdata` is valid in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per T-state |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_req | input | 1 | Core requests a machine cycle (taken while idle) |
| cyc_type | input | 3 | Cycle type: 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| cyc_last | input | 1 | Requested cycle is the last one of its instruction |
| cyc_addr | input | 16 | Address of the requested cycle |
| cyc_wdata | input | 8 | Write data of the requested cycle |
| cyc_done | output | 1 | One-clock pulse after a cycle ends |
| cyc_rdata | output | 8 | Captured read or fetch data |
| irq_pend | output | 1 | One-clock pulse: interrupt seen at an instruction boundary |
| ivec | input | 8 | Interrupt-vector register contents |
| rr_load | input | 1 | Load the refresh register |
| rr_din | input | 8 | Value for the refresh register load |
| addr | output | 16 | Address bus |
| dout | output | 8 | Data bus output |
| din | input | 8 | Data bus input |
| mreq_n | output | 1 | Memory request strobe |
| iorq_n | output | 1 | I/O request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| rfsh_n | output | 1 | Refresh strobe |
| m1_n | output | 1 | Opcode-fetch indicator |
| bus_en_n | output | 1 | Low while the block drives address, data and strobes |
| wait_n | input | 1 | Wait request from a slow device |
| busreq_n | input | 1 | External bus request |
| busack_n | output | 1 | Bus grant acknowledge |
| int_n | input | 1 | Maskable interrupt request |

## Verification
A corrupted state register shows up within one clock as a strobe pattern that does not fit the cycle type, or as a cycle one state too long or too short. The bench records every strobe in every state of each cycle, so it reports such errors at the first wrong state. A wrong refresh count stays hidden until the next fetch reaches T3, and at that point the low address byte reveals it. A wrongly latched instruction-boundary flag shows only in the done clock of a cycle that ends while `int_n` is low. For this reason the interrupt checks pair both settings of `cyc_last` with an interrupt request that is held low and one that is pulsed.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    CT_FETCH = 3'd0,
    CT_MRD   = 3'd1,
    CT_MWR   = 3'd2,
    CT_IORD  = 3'd3,
    CT_IOWR  = 3'd4
  } cyc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_TA, S_TW, S_T3, S_T4, S_HOLD
  } st_t;
endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm import bcs_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_req,
  input  logic [2:0]    cyc_type,
  input  logic          cyc_last,
  input  logic [AW-1:0] cyc_addr,
  input  logic [DW-1:0] cyc_wdata,
  input  logic [DW-1:0] din,
  input  logic          wait_n,
  input  logic          busreq_n,
  input  logic          int_n,
  output st_t           state,
  output cyc_t          ctype,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          irq_pend,
  output logic          fetch_end
);
  st_t  st_q, st_d;
  cyc_t ctype_q;
  logic last_q;
  logic accept, cyc_end, cap;
  logic is_io, is_fetch, is_read;

  assign is_io    = (ctype_q == CT_IORD) || (ctype_q == CT_IOWR);
  assign is_fetch = (ctype_q == CT_FETCH);
  assign is_read  = (ctype_q == CT_MRD) || (ctype_q == CT_IORD);
  assign accept   = (st_q == S_IDLE) && busreq_n && cyc_req;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cyc_end = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (!busreq_n)    st_d = S_HOLD;
        else if (cyc_req) st_d = S_T1;
      end
      S_T1: st_d = S_T2;
      S_T2: begin
        if (is_io)        st_d = S_TA;
        else if (!wait_n) st_d = S_TW;
        else              st_d = S_T3;
      end
      S_TA:   st_d = wait_n ? S_T3 : S_TW;
      S_TW:   st_d = wait_n ? S_T3 : S_TW;
      S_T3: begin
        if (is_fetch) st_d = S_T4;
        else          cyc_end = 1'b1;
      end
      S_T4:   cyc_end = 1'b1;
      S_HOLD: if (busreq_n) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (cyc_end) st_d = busreq_n ? S_IDLE : S_HOLD;
  end

  assign cap = is_fetch ? (((st_q == S_T2) || (st_q == S_TW)) && (st_d == S_T3))
                        : (cyc_end && is_read);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      ctype_q  <= CT_FETCH;
      addr_q   <= '0;
      wdata_q  <= '0;
      last_q   <= 1'b0;
      rdata    <= '0;
      done     <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      st_q     <= st_d;
      done     <= cyc_end;
      irq_pend <= cyc_end && last_q && !int_n;
      if (accept) begin
        ctype_q <= cyc_t'(cyc_type);
        addr_q  <= cyc_addr;
        wdata_q <= cyc_wdata;
        last_q  <= cyc_last;
      end
      if (cap) rdata <= din;
    end
  end

  assign state     = st_q;
  assign ctype     = ctype_q;
  assign fetch_end = cyc_end && is_fetch;

  // R2: a fetch always continues from T3 into T4
  p_fetch_t4_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_T3 && is_fetch) |=> (st_q == S_T4));
  // R6: I/O cycles always pass through the automatic wait state
  p_io_auto_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_T2 && is_io) |=> (st_q == S_TA));
  // R7: a low wait sample in a wait state adds another
  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TW && !wait_n) |=> (st_q == S_TW));
  // R8: no grant in the middle of a machine cycle
  p_no_mid_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_T1 || st_q == S_T2 || st_q == S_TA) |=> (st_q != S_HOLD));
  // R8: release of the request returns to idle
  p_hold_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HOLD && busreq_n) |=> (st_q == S_IDLE));
  // R9: interrupt flag only with done of an instruction's last cycle
  p_irq_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (done && last_q));
  // R10: done is a single-clock pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/bcs_refresh.sv
module bcs_refresh #(
  parameter int RFW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld,
  input  logic [RFW-1:0] ld_val,
  input  logic           inc,
  output logic [RFW-1:0] rr
);
  localparam int CW = RFW - 1;

  logic [RFW-1:0] rr_q, rr_d;
  logic [CW-1:0]  low_inc;

  assign low_inc = rr_q[CW-1:0] + {{(CW-1){1'b0}}, 1'b1};

  always_comb begin
    rr_d = rr_q;
    if (ld)       rr_d = ld_val;
    else if (inc) rr_d = {rr_q[RFW-1], low_inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else if (ld || inc) rr_q <= rr_d;
  end

  assign rr = rr_q;

  // R4: the top bit survives counting
  p_msb_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld) |=> (rr_q[RFW-1] == $past(rr_q[RFW-1])));
  // R4: low bits advance by one per fetch
  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld) |=> (rr_q[CW-1:0] == CW'($past(rr_q[CW-1:0]) + 1'b1)));
  // R4: a load takes the whole byte
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (rr_q == $past(ld_val)));
endmodule

// File: rtl/bcs_strobes.sv
module bcs_strobes import bcs_pkg::*; #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int RFW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_t               state,
  input  cyc_t              ctype,
  input  logic [AW-1:0]     addr_q,
  input  logic [DW-1:0]     wdata_q,
  input  logic [AW-RFW-1:0] ivec,
  input  logic [RFW-1:0]    rr,
  output logic [AW-1:0]     addr,
  output logic [DW-1:0]     dout,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              rfsh_n,
  output logic              m1_n,
  output logic              bus_en_n,
  output logic              busack_n
);
  logic act, early, mid, late, rfp;

  assign act   = (state inside {S_T1, S_T2, S_TA, S_TW, S_T3, S_T4});
  assign early = (state inside {S_T1, S_T2, S_TW});
  assign mid   = (state inside {S_T2, S_TA, S_TW, S_T3});
  assign late  = (state inside {S_T2, S_TW, S_T3});
  assign rfp   = (state inside {S_T3, S_T4});

  always_comb begin
    m1_n   = 1'b1;
    mreq_n = 1'b1;
    iorq_n = 1'b1;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    rfsh_n = 1'b1;
    addr   = addr_q;
    case (ctype)
      CT_FETCH: begin
        m1_n   = !early;
        mreq_n = !act;
        rd_n   = !early;
        rfsh_n = !rfp;
        if (rfp) addr = {ivec, rr};
      end
      CT_MRD: begin
        mreq_n = !act;
        rd_n   = !act;
      end
      CT_MWR: begin
        mreq_n = !act;
        wr_n   = !late;
      end
      CT_IORD: begin
        iorq_n = !mid;
        rd_n   = !mid;
      end
      CT_IOWR: begin
        iorq_n = !mid;
        wr_n   = !mid;
      end
      default: ;
    endcase
  end

  assign dout     = wdata_q;
  assign bus_en_n = (state == S_HOLD);
  assign busack_n = (state != S_HOLD);

  // R6: memory and I/O space never requested together
  p_one_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mreq_n && !iorq_n));
  // R5: read and write strobes exclusive
  p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R3: refresh is a memory access without read or fetch indicator
  p_rfsh_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (m1_n && rd_n && !mreq_n));
  // R8: a granted bus is fully released
  p_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busack_n |-> (bus_en_n && mreq_n && iorq_n && rd_n && wr_n && rfsh_n && m1_n));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq import bcs_pkg::*; #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int RFW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_req,
  input  logic [2:0]        cyc_type,
  input  logic              cyc_last,
  input  logic [AW-1:0]     cyc_addr,
  input  logic [DW-1:0]     cyc_wdata,
  output logic              cyc_done,
  output logic [DW-1:0]     cyc_rdata,
  output logic              irq_pend,
  input  logic [AW-RFW-1:0] ivec,
  input  logic              rr_load,
  input  logic [RFW-1:0]    rr_din,
  output logic [AW-1:0]     addr,
  output logic [DW-1:0]     dout,
  input  logic [DW-1:0]     din,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              rfsh_n,
  output logic              m1_n,
  output logic              bus_en_n,
  input  logic              wait_n,
  input  logic              busreq_n,
  output logic              busack_n,
  input  logic              int_n
);
  logic [1:0]    rst_sync;
  logic          rst_s_n;
  st_t           state;
  cyc_t          ctype;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          fetch_end;
  logic [RFW-1:0] rr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  bcs_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .cyc_req(cyc_req), .cyc_type(cyc_type),
    .cyc_last(cyc_last), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
    .din(din), .wait_n(wait_n), .busreq_n(busreq_n), .int_n(int_n),
    .state(state), .ctype(ctype), .addr_q(addr_q), .wdata_q(wdata_q),
    .rdata(cyc_rdata), .done(cyc_done), .irq_pend(irq_pend),
    .fetch_end(fetch_end)
  );

  bcs_refresh #(.RFW(RFW)) u_rfsh (
    .clk(clk), .rst_n(rst_s_n), .ld(rr_load), .ld_val(rr_din),
    .inc(fetch_end), .rr(rr)
  );

  bcs_strobes #(.AW(AW), .DW(DW), .RFW(RFW)) u_strb (
    .clk(clk), .rst_n(rst_s_n), .state(state), .ctype(ctype),
    .addr_q(addr_q), .wdata_q(wdata_q), .ivec(ivec), .rr(rr),
    .addr(addr), .dout(dout), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n), .m1_n(m1_n),
    .bus_en_n(bus_en_n), .busack_n(busack_n)
  );
endmodule

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic cyc_req, cyc_last, rr_load, wait_n, busreq_n, int_n;
  logic [2:0]  cyc_type;
  logic [15:0] cyc_addr, addr;
  logic [7:0]  cyc_wdata, cyc_rdata, ivec, rr_din, dout, din;
  logic cyc_done, irq_pend, mreq_n, iorq_n, rd_n, wr_n, rfsh_n, m1_n, bus_en_n, busack_n;

  always #2.5 clk = ~clk;

  bus_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .cyc_type(cyc_type),
    .cyc_last(cyc_last), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
    .cyc_done(cyc_done), .cyc_rdata(cyc_rdata), .irq_pend(irq_pend),
    .ivec(ivec), .rr_load(rr_load), .rr_din(rr_din), .addr(addr),
    .dout(dout), .din(din), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .rfsh_n(rfsh_n), .m1_n(m1_n), .bus_en_n(bus_en_n),
    .wait_n(wait_n), .busreq_n(busreq_n), .busack_n(busack_n), .int_n(int_n)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [7:0]  rr_m;
  logic [5:0]  rec_s [0:63];
  logic [15:0] rec_a [0:63];
  logic [7:0]  rec_d [0:63];
  int          nst;
  logic [7:0]  got_rdata;
  logic        got_irq, got_ack, got_en, done_after, irq_after;
  logic [5:0]  got_s;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // phase of state j: 1 T1, 2 T2, 3 auto wait, 4 wait, 5 T3, 6 T4
  function automatic int ph(int ty, int nw, int j);
    int base = (ty == 3 || ty == 4) ? 3 : 2;
    if (j == 1) return 1;
    if (j == 2) return 2;
    if (base == 3 && j == 3) return 3;
    if (j <= base + nw) return 4;
    if (j == base + nw + 1) return 5;
    return 6;
  endfunction

  // expected {m1, mreq, iorq, rd, wr, rfsh}
  function automatic logic [5:0] exp_s(int ty, int p);
    logic m1 = 1'b1, mr = 1'b1, io = 1'b1, rd = 1'b1, wr = 1'b1, rf = 1'b1;
    case (ty)
      0: begin m1 = !(p == 1 || p == 2 || p == 4); mr = 1'b0; rd = m1; rf = !(p == 5 || p == 6); end
      1: begin mr = 1'b0; rd = 1'b0; end
      2: begin mr = 1'b0; wr = (p == 1); end
      3: begin io = (p == 1); rd = (p == 1); end
      4: begin io = (p == 1); wr = (p == 1); end
      default: ;
    endcase
    return {m1, mr, io, rd, wr, rf};
  endfunction

  task automatic run(input string tag, input int ty, input logic [15:0] a,
                     input logic [7:0] wd, input bit last, input int nw,
                     input logic [7:0] dv, input int brq_at, input int imode);
    int base = (ty == 3 || ty == 4) ? 3 : 2;
    int exp_n = base + nw + 1 + ((ty == 0) ? 1 : 0);
    int bad_s = 0, bad_a = 0;
    @(negedge clk);
    cyc_type = ty[2:0]; cyc_addr = a; cyc_wdata = wd; cyc_last = last;
    cyc_req = 1'b1; wait_n = 1'b1; int_n = (imode == 1) ? 1'b0 : 1'b1; din = dv;
    @(negedge clk);
    cyc_req = 1'b0;
    nst = -1;
    for (int j = 1; j < 60; j++) begin
      if (cyc_done) begin nst = j - 1; break; end
      rec_s[j] = {m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n};
      rec_a[j] = addr;
      rec_d[j] = dout;
      wait_n = !(j >= base && j < base + nw);
      din = (ty == 0 && j > 2 + nw) ? 8'hEE : dv;
      if (brq_at > 0 && j >= brq_at) busreq_n = 1'b0;
      if (imode == 2) int_n = (j == 1) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    got_rdata = cyc_rdata; got_irq = irq_pend; got_ack = busack_n; got_en = bus_en_n;
    got_s = {m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n};
    int_n = 1'b1; wait_n = 1'b1;
    chk(nst == exp_n, tag, "state count", nst, exp_n);
    for (int j = 1; j <= nst && j < 60; j++) begin
      logic [15:0] ea;
      int p = ph(ty, nw, j);
      ea = (ty == 0 && p >= 5) ? {ivec, rr_m} : a;
      if (rec_s[j] !== exp_s(ty, p) && bad_s == 0) begin
        bad_s = 1;
        chk(0, tag, $sformatf("strobes in state %0d", j), rec_s[j], exp_s(ty, p));
      end
      if (rec_a[j] !== ea && bad_a == 0) begin
        bad_a = 1;
        chk(0, (ty == 0) ? "R3" : tag, $sformatf("addr in state %0d", j), rec_a[j], ea);
      end
    end
    if (bad_s == 0) chk(1, tag, "strobes", 0, 0);
    if (bad_a == 0) chk(1, "R3", "addr", 0, 0);
    if (ty == 0 || ty == 1 || ty == 3)
      chk(got_rdata == dv, (ty == 0) ? "R2" : "R10", "read data", got_rdata, dv);
    if (ty == 0) rr_m = {rr_m[7], rr_m[6:0] + 7'd1};
    @(negedge clk);
    done_after = cyc_done; irq_after = irq_pend;
    chk(!done_after && !irq_after, "R10", "done/irq single pulse",
        {done_after, irq_after}, 0);
  endtask

  task automatic t_reset();
    chk({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n} == 6'h3F, "R1", "strobes idle",
        {m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n}, 6'h3F);
    chk(busack_n == 1'b1 && bus_en_n == 1'b0, "R1", "bus ack/enable",
        {busack_n, bus_en_n}, 2'b10);
    chk(cyc_done == 1'b0 && irq_pend == 1'b0, "R1", "done/irq low",
        {cyc_done, irq_pend}, 0);
  endtask

  task automatic t_fetch();
    ivec = 8'h3C;
    run("R2", 0, 16'h1234, 8'h00, 1'b0, 0, 8'hA5, 0, 0);   // refresh starts at 00 (R1)
    run("R7", 0, 16'h2345, 8'h00, 1'b0, 2, 8'h5B, 0, 0);
  endtask

  task automatic t_mem();
    run("R5", 1, 16'h8001, 8'h00, 1'b0, 0, 8'h5A, 0, 0);
    run("R5", 2, 16'h4002, 8'hC3, 1'b0, 0, 8'h00, 0, 0);
    chk(rec_d[2] == 8'hC3, "R5", "write data on dout", rec_d[2], 8'hC3);
    run("R7", 2, 16'h4003, 8'h3C, 1'b0, 1, 8'h00, 0, 0);
  endtask

  task automatic t_io();
    run("R6", 3, 16'h00FE, 8'h00, 1'b0, 0, 8'h77, 0, 0);
    run("R7", 4, 16'h00F1, 8'h91, 1'b0, 2, 8'h00, 0, 0);
  endtask

  task automatic t_refresh();
    @(negedge clk); rr_load = 1'b1; rr_din = 8'hFE;
    @(negedge clk); rr_load = 1'b0;
    rr_m = 8'hFE;
    ivec = 8'h41;
    run("R4", 0, 16'h0100, 8'h00, 1'b0, 0, 8'h11, 0, 0);
    run("R4", 0, 16'h0101, 8'h00, 1'b0, 0, 8'h12, 0, 0);
    run("R4", 0, 16'h0102, 8'h00, 1'b0, 0, 8'h13, 0, 0);  // low byte 80: bit 7 kept on wrap
    chk(rr_m == 8'h81, "R4", "model after wrap", rr_m, 8'h81);
  endtask

  task automatic t_busreq();
    run("R8", 1, 16'h9000, 8'h00, 1'b0, 0, 8'h44, 1, 0);
    chk(got_ack == 1'b0 && got_en == 1'b1, "R8", "grant after cycle end",
        {got_ack, got_en}, 2'b01);
    chk(got_s == 6'h3F, "R8", "strobes released in grant", got_s, 6'h3F);
    repeat (3) @(negedge clk);
    chk(busack_n == 1'b0 && bus_en_n == 1'b1, "R8", "grant held", {busack_n, bus_en_n}, 2'b01);
    busreq_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(busack_n == 1'b1 && bus_en_n == 1'b0, "R8", "grant released",
        {busack_n, bus_en_n}, 2'b10);
    run("R8", 0, 16'h9001, 8'h00, 1'b0, 0, 8'h45, 0, 0);
  endtask

  task automatic t_irq();
    run("R9", 1, 16'h0200, 8'h00, 1'b0, 0, 8'h01, 0, 1);
    chk(got_irq == 1'b0, "R9", "no irq on non-last cycle", got_irq, 0);
    run("R9", 1, 16'h0201, 8'h00, 1'b1, 0, 8'h02, 0, 1);
    chk(got_irq == 1'b1, "R9", "irq at instruction end", got_irq, 1);
    run("R9", 0, 16'h0202, 8'h00, 1'b1, 0, 8'h03, 0, 2);
    chk(got_irq == 1'b0, "R9", "mid-cycle pulse ignored", got_irq, 0);
  endtask

  initial begin
    rst_n = 1'b0; cyc_req = 1'b0; cyc_type = 3'd0; cyc_last = 1'b0;
    cyc_addr = 16'h0; cyc_wdata = 8'h0; ivec = 8'h0; rr_load = 1'b0;
    rr_din = 8'h0; din = 8'h0; wait_n = 1'b1; busreq_n = 1'b1; int_n = 1'b1;
    rr_m = 8'h00;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fetch();
    t_mem();
    t_io();
    t_refresh();
    t_busreq();
    t_irq();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule